// File: doc/BRIEF.md
# DMA Fault Status Capture

This block sits beside an address translation unit and keeps a record of the first DMA translation fault. The translation logic pulses a fault strobe carrying the fault's attributes: whether it was a segment fault or a page fault, the page address, whether the access was a read, and the requester ID. If that fault type is enabled in the mask register and no fault is already pending, the block captures it into a sticky status register and raises its interrupt.

Software reads the status register, handles the fault, and re-arms the unit by writing the status value back with the top (valid) bit cleared. While a record is pending, later faults are dropped. The fault strobe takes no back-pressure. It is a single-cycle valid pulse with no ready, and a fault that cannot be captured is simply lost. The register port is a plain write strobe with an address and write data. Read data depends combinationally on the address.

Register offsets (12-bit address): status at 0x920, mask at 0x928.

Top module: `dma_fault_capture`

## Requirements
- R1: After reset, the status register reads 0, the mask register reads 0, and `irq` is low.
- R2: The mask register at offset 0x928 is writable and readable. Bit 62 enables segment-fault capture and bit 61 enables page-fault capture. All other bits read as 0.
- R3: A fault whose type is enabled, arriving while no record is pending, is visible at offset 0x920 one cycle later. The status fields are:
  - bit 63 = 1 (valid);
  - bits 62:61 = 11 for a segment fault or 01 for a page fault;
  - bits 34:12 = page address;
  - bit 11 = 1 for a read and 0 for a write;
  - bits 10:0 = requester ID;
  - all other bits = 0.
- R4: A fault whose type bit in the mask register is 0 is not captured. The status register and `irq` stay unchanged.
- R5: While the valid bit is set, later faults are dropped and the record does not change.
- R6: Writing offset 0x920 with bit 63 = 0 clears the valid bit and keeps the other fields readable. A write to 0x920 with bit 63 = 1 changes nothing.
- R7: `irq` is high exactly when the valid bit is set and the mask bit for the recorded fault type is set. A mask change affects `irq` from the cycle after the write.
- R8: A fault that arrives in the same cycle as a clearing write to the status register is captured.
- R9: Writes to any offset other than 0x920 and 0x928 have no effect, and reads of such offsets return 0.
- R10: A fault that arrives in the same cycle as a mask write is judged against the mask value held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 1 | Fault strobe, one cycle per fault |
| flt_seg | input | 1 | 1 = segment fault, 0 = page fault |
| flt_page | input | 23 | Faulting page address |
| flt_rd | input | 1 | 1 = read access, 0 = write |
| flt_id | input | 11 | Requester ID |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 12 | Register byte offset |
| csr_wdata | input | 64 | Register write data |
| csr_rdata | output | 64 | Read data for `csr_addr` |
| irq | output | 1 | Fault interrupt |

## Verification
The bench drives two kinds of fault with different field values, in the following conditions:
- with both types enabled;
- with only one type enabled;
- with neither type enabled.

These cases separate type encoding, field placement and mask gating. Sticky behaviour is checked by a second fault that carries different attributes while a record is pending. Two cycle-level races are exercised: a fault in the same cycle as a clearing write, and a fault in the same cycle as a mask write. Together they pin down the priority between capture, clear and mask update. Writes to unrelated offsets and writes with the valid bit set check that only the intended write clears the record.

// File: rtl/dmaexc_pkg.sv
package dmaexc_pkg;
  localparam int PAGE_W   = 23;
  localparam int ID_W     = 11;
  localparam int REG_W    = 64;
  localparam int V_BIT    = 63;
  localparam int KIND_LSB = 61;
  localparam int PAGE_LSB = 12;
  localparam int RD_BIT   = 11;
  localparam int SEG_EN_BIT  = 62;
  localparam int PAGE_EN_BIT = 61;

  typedef enum logic [1:0] {
    KIND_NONE = 2'b00,
    KIND_PAGE = 2'b01,
    KIND_SEG  = 2'b11
  } fkind_e;

  typedef struct packed {
    fkind_e             kind;
    logic [PAGE_W-1:0]  page;
    logic               rd;
    logic [ID_W-1:0]    id;
  } frec_t;

  function automatic logic [REG_W-1:0] pack_status(logic v, frec_t r);
    logic [REG_W-1:0] w;
    w = '0;
    w[V_BIT] = v;
    w[KIND_LSB +: 2] = r.kind;
    w[PAGE_LSB +: PAGE_W] = r.page;
    w[RD_BIT] = r.rd;
    w[ID_W-1:0] = r.id;
    return w;
  endfunction
endpackage

// File: rtl/dmaexc_mask_reg.sv
module dmaexc_mask_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic seg_en_d,
  input  logic page_en_d,
  output logic seg_en,
  output logic page_en
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_en  <= 1'b0;
      page_en <= 1'b0;
    end else if (wr_en) begin
      seg_en  <= seg_en_d;
      page_en <= page_en_d;
    end
  end

  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(seg_en) && $stable(page_en)));
endmodule

// File: rtl/dmaexc_record.sv
module dmaexc_record
  import dmaexc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flt_valid,
  input  logic              flt_seg,
  input  logic [PAGE_W-1:0] flt_page,
  input  logic              flt_rd,
  input  logic [ID_W-1:0]   flt_id,
  input  logic              seg_en,
  input  logic              page_en,
  input  logic              clr_req,
  output logic              rec_valid,
  output frec_t             rec
);
  logic  type_on;
  logic  slot_free;
  logic  take;
  frec_t incoming;

  always_comb begin
    type_on   = flt_seg ? seg_en : page_en;
    slot_free = !rec_valid || clr_req;
    take      = flt_valid && type_on && slot_free;
    incoming.kind = flt_seg ? KIND_SEG : KIND_PAGE;
    incoming.page = flt_page;
    incoming.rd   = flt_rd;
    incoming.id   = flt_id;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_valid <= 1'b0;
      rec       <= '{kind: KIND_NONE, page: '0, rd: 1'b0, id: '0};
    end else if (take) begin
      rec_valid <= 1'b1;
      rec       <= incoming;
    end else if (clr_req) begin
      rec_valid <= 1'b0;
    end
  end

  assert_masked_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && !type_on && slot_free) |=> !rec_valid);

  assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !clr_req) |=> (rec_valid && $stable(rec)));

  assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !flt_valid) |=> !rec_valid);

  assert_race_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && flt_valid && type_on) |=> (rec_valid && rec.id == $past(flt_id)));

  assert_capture_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_valid) |-> ($past(flt_valid) &&
                          ($past(flt_seg) ? $past(seg_en) : $past(page_en))));
endmodule

// File: rtl/dmaexc_irq_gen.sv
module dmaexc_irq_gen
  import dmaexc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   rec_valid,
  input  fkind_e kind,
  input  logic   seg_en,
  input  logic   page_en,
  output logic   irq
);
  logic kind_enabled;

  always_comb begin
    unique case (kind)
      KIND_SEG:  kind_enabled = seg_en;
      KIND_PAGE: kind_enabled = page_en;
      default:   kind_enabled = 1'b0;
    endcase
    irq = rec_valid && kind_enabled;
  end

  assert_irq_needs_record_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rec_valid && (seg_en || page_en)));
endmodule

// File: rtl/dma_fault_capture.sv
module dma_fault_capture
  import dmaexc_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int STAT_OFS = 'h920,
  parameter int MASK_OFS = 'h928
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flt_valid,
  input  logic              flt_seg,
  input  logic [PAGE_W-1:0] flt_page,
  input  logic              flt_rd,
  input  logic [ID_W-1:0]   flt_id,
  input  logic              csr_wr,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [REG_W-1:0]  csr_wdata,
  output logic [REG_W-1:0]  csr_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);

  logic  stat_hit, mask_hit;
  logic  clr_req, mask_wr;
  logic  seg_en, page_en;
  logic  rec_valid;
  frec_t rec;

  always_comb begin
    stat_hit = (csr_addr == STAT_A);
    mask_hit = (csr_addr == MASK_A);
    clr_req  = csr_wr && stat_hit && !csr_wdata[V_BIT];
    mask_wr  = csr_wr && mask_hit;
  end

  dmaexc_mask_reg u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (mask_wr),
    .seg_en_d  (csr_wdata[SEG_EN_BIT]),
    .page_en_d (csr_wdata[PAGE_EN_BIT]),
    .seg_en    (seg_en),
    .page_en   (page_en)
  );

  dmaexc_record u_rec (
    .clk       (clk),
    .rst_n     (rst_n),
    .flt_valid (flt_valid),
    .flt_seg   (flt_seg),
    .flt_page  (flt_page),
    .flt_rd    (flt_rd),
    .flt_id    (flt_id),
    .seg_en    (seg_en),
    .page_en   (page_en),
    .clr_req   (clr_req),
    .rec_valid (rec_valid),
    .rec       (rec)
  );

  dmaexc_irq_gen u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rec_valid (rec_valid),
    .kind      (rec.kind),
    .seg_en    (seg_en),
    .page_en   (page_en),
    .irq       (irq)
  );

  always_comb begin
    csr_rdata = '0;
    if (stat_hit) begin
      csr_rdata = pack_status(rec_valid, rec);
    end else if (mask_hit) begin
      csr_rdata[SEG_EN_BIT]  = seg_en;
      csr_rdata[PAGE_EN_BIT] = page_en;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!irq && !rec_valid));

  assert_set_valid_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && stat_hit && csr_wdata[V_BIT] && !flt_valid) |=> $stable(rec_valid));
endmodule

// File: tb/dma_fault_capture_tb_top.sv
module dma_fault_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flt_valid = 1'b0;
  logic        flt_seg = 1'b0;
  logic [22:0] flt_page = '0;
  logic        flt_rd = 1'b0;
  logic [10:0] flt_id = '0;
  logic        csr_wr = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  localparam logic [11:0] A_STAT = 12'h920;
  localparam logic [11:0] A_MASK = 12'h928;
  localparam logic [63:0] M_BOTH = 64'h6000_0000_0000_0000;
  localparam logic [63:0] M_SEG  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] M_PAGE = 64'h2000_0000_0000_0000;

  always #10 clk = ~clk;

  dma_fault_capture dut_i (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_seg(flt_seg),
    .flt_page(flt_page), .flt_rd(flt_rd), .flt_id(flt_id), .csr_wr(csr_wr),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq)
  );

  function automatic logic [63:0] exp_stat(bit v, bit seg, logic [22:0] pg, bit rd, logic [10:0] id);
    return {v, seg ? 2'b11 : 2'b01, 26'd0, pg, rd, id};
  endfunction

  task automatic check64(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic rd_check(string req, logic [11:0] a, logic [63:0] exp);
    csr_addr = a;
    #1;
    check64(req, "read", csr_rdata, exp);
  endtask

  task automatic irq_check(string req, bit exp);
    check64(req, "irq", {63'd0, irq}, {63'd0, exp});
  endtask

  // Drive on negedge, one cycle; sampling follows at the next negedge.
  task automatic cycle(bit wr, logic [11:0] a, logic [63:0] d,
                       bit fv, bit seg, logic [22:0] pg, bit rd, logic [10:0] id);
    csr_wr = wr; csr_addr = a; csr_wdata = d;
    flt_valid = fv; flt_seg = seg; flt_page = pg; flt_rd = rd; flt_id = id;
    @(negedge clk);
    csr_wr = 1'b0; flt_valid = 1'b0;
  endtask

  task automatic wr(logic [11:0] a, logic [63:0] d);
    cycle(1'b1, a, d, 1'b0, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic fault(bit seg, logic [22:0] pg, bit rd, logic [10:0] id);
    cycle(1'b0, A_STAT, '0, 1'b1, seg, pg, rd, id);
  endtask

  task automatic t_reset;
    rd_check("R1", A_STAT, 64'd0);
    rd_check("R1", A_MASK, 64'd0);
    irq_check("R1", 1'b0);
  endtask

  task automatic t_mask_rw;
    wr(A_MASK, '1);
    rd_check("R2", A_MASK, M_BOTH);
    wr(A_MASK, M_PAGE);
    rd_check("R2", A_MASK, M_PAGE);
    wr(A_MASK, 64'd0);
    rd_check("R2", A_MASK, 64'd0);
  endtask

  task automatic t_masked_drop;
    fault(1'b1, 23'h1, 1'b1, 11'h1);
    rd_check("R4", A_STAT, 64'd0);
    irq_check("R4", 1'b0);
    wr(A_MASK, M_PAGE);
    fault(1'b1, 23'h2, 1'b0, 11'h2);
    rd_check("R4", A_STAT, 64'd0);
    irq_check("R4", 1'b0);
  endtask

  task automatic t_capture_and_sticky;
    wr(A_MASK, M_BOTH);
    fault(1'b0, 23'h12345, 1'b1, 11'h5A3);
    rd_check("R3", A_STAT, exp_stat(1, 0, 23'h12345, 1, 11'h5A3));
    irq_check("R7", 1'b1);
    fault(1'b1, 23'h7FFFFF, 1'b0, 11'h7FF);
    rd_check("R5", A_STAT, exp_stat(1, 0, 23'h12345, 1, 11'h5A3));
  endtask

  task automatic t_irq_mask;
    wr(A_MASK, M_SEG);
    irq_check("R7", 1'b0);
    rd_check("R7", A_STAT, exp_stat(1, 0, 23'h12345, 1, 11'h5A3));
    wr(A_MASK, M_BOTH);
    irq_check("R7", 1'b1);
  endtask

  task automatic t_other_addr;
    wr(12'h930, 64'd0);
    rd_check("R9", A_STAT, exp_stat(1, 0, 23'h12345, 1, 11'h5A3));
    rd_check("R9", 12'h930, 64'd0);
    wr(A_STAT, exp_stat(1, 1, 23'h0, 0, 11'h0));
    rd_check("R6", A_STAT, exp_stat(1, 0, 23'h12345, 1, 11'h5A3));
  endtask

  task automatic t_clear;
    wr(A_STAT, exp_stat(0, 0, 23'h12345, 1, 11'h5A3));
    rd_check("R6", A_STAT, exp_stat(0, 0, 23'h12345, 1, 11'h5A3));
    irq_check("R6", 1'b0);
  endtask

  task automatic t_capture_seg;
    fault(1'b1, 23'h7FFFFF, 1'b0, 11'h7FF);
    rd_check("R3", A_STAT, exp_stat(1, 1, 23'h7FFFFF, 0, 11'h7FF));
    irq_check("R7", 1'b1);
  endtask

  task automatic t_race_clear;
    cycle(1'b1, A_STAT, 64'd0, 1'b1, 1'b0, 23'h00ABC, 1'b0, 11'h00F);
    rd_check("R8", A_STAT, exp_stat(1, 0, 23'h00ABC, 0, 11'h00F));
    wr(A_STAT, 64'd0);
  endtask

  task automatic t_race_mask;
    wr(A_MASK, 64'd0);
    cycle(1'b1, A_MASK, M_BOTH, 1'b1, 1'b1, 23'h55, 1'b1, 11'h33);
    rd_check("R10", A_STAT, exp_stat(0, 0, 23'h00ABC, 0, 11'h00F));
    fault(1'b1, 23'h55, 1'b1, 11'h33);
    rd_check("R10", A_STAT, exp_stat(1, 1, 23'h55, 1, 11'h33));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask_rw();
    t_masked_drop();
    t_capture_and_sticky();
    t_irq_mask();
    t_other_addr();
    t_clear();
    t_capture_seg();
    t_race_clear();
    t_race_mask();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule